// File: doc/BRIEF.md
# Dual-Half Countdown and Seconds Timer

This block is a register-programmed timer built from two 16-bit halves. In the joined configurations the halves act as one 32-bit value. Configuration 0 runs a 32-bit down-counter that steps once per count-enable pulse. Configuration 1 runs a seconds counter that steps once per 1 Hz enable pulse and flags when it reaches a 32-bit compare value. Configurations 4 and up only store the halves separately and never start a count.

Software sets the block up through a single-cycle write port with a combinational read. An interrupt line stays high while any enabled status bit is set. An optional one-cycle trigger pulse marks each countdown timeout, so a sampling block can be started directly.

Timer A is driven by a small state machine with three states:
- `ST_IDLE`: stopped.
- `ST_COUNT`: counting down.
- `ST_RTC`: counting seconds.

Its named transitions:
- START_COUNT: `ST_IDLE` to `ST_COUNT`, taken when the A run bit rises while the configuration is 0.
- START_RTC: `ST_IDLE` to `ST_RTC`, taken when the A run bit rises while the configuration is 1.
- SPLIT_IGNORE: stays in `ST_IDLE` when the A run bit rises while the configuration is 4 or more.
- STOP: any state to `ST_IDLE` when the A run bit falls.
- RELOAD: `ST_COUNT` to `ST_COUNT` on a periodic timeout.
- ONESHOT_DONE: `ST_COUNT` to `ST_IDLE` on a one-shot timeout.

Top module: `twin_half_timer`

## Requirements
Register byte offsets:

| Offset | Register |
|---|---|
| 0x00 | configuration, bits 2:0 |
| 0x04 | mode A, bit 0 = one-shot |
| 0x08 | mode B |
| 0x0C | control: bit 0 = A run, bit 5 = trigger enable, bit 8 = B run, 16 bits stored |
| 0x10 | interrupt mask |
| 0x14 | raw status |
| 0x18 | masked status |
| 0x1C | status clear |
| 0x20 | A load |
| 0x24 | B load |
| 0x28 | A match |
| 0x2C | B match |
| 0x30 | A prescale |
| 0x34 | B prescale |
| 0x38 | A prescale-match |
| 0x3C | B prescale-match |
| 0x40 | count value |

Unlisted offsets read as 0.

- R1: After reset every register reads 0, the interrupt output is 0 and the trigger output is 0.
- R2: With configuration 0, a write that changes control bit 0 from 0 to 1 loads the counter with {high half, low half} of the load pair. Each count-enable pulse then decrements it. The pulse that takes it from 1 to 0 sets raw status bit 0. The counter value reads at 0x40 when the configuration is not 1.
- R3: Mode A bit 0 clear makes a timeout reload the load value and keep counting. With the bit set, the counter stays at 0 and stops, so later pulses set no status.
- R4: When control bit 5 is set, each countdown timeout gives a trigger output pulse of exactly one cycle, in the cycle the status bit appears. With bit 5 clear there is no pulse.
- R5: With configuration 1, starting clears the seconds count. Each 1 Hz enable pulse adds one. The pulse that makes the count equal {match high, match low} sets raw status bit 2, which stays set. The count reads at 0x40.
- R6: A write to 0x20 or 0x28 stores data bits 15:0 in the low half. In configurations below 4 it also stores bits 31:16 in the high half. Writes to 0x24 and 0x2C store data bits 15:0 into the high half.
- R7: Reading 0x20 or 0x28 returns {high, low} when the configuration is below 4, and only the low half otherwise. Reading 0x24 or 0x2C returns the high half. The prescale registers keep their low 8 bits.
- R8: The mask keeps only bits set in 0x77. The interrupt output is high exactly while raw status AND mask is non-zero. The masked status read returns raw status AND mask.
- R9: Writing ones to 0x1C clears those raw status bits the next cycle. A status event in the same cycle as its clear leaves the bit set.
- R10: A control write that leaves bit 0 unchanged neither restarts nor reloads the counter. Clearing bit 0 stops counting. Setting bit 0 in configuration 4 or above starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_addr | input | ADDR_W (7) | byte offset of the register |
| bus_wdata | input | 2*HALF_W (32) | write data |
| bus_rdata | output | 2*HALF_W (32) | combinational read data for bus_addr |
| cnt_tick | input | 1 | count enable for the countdown |
| sec_tick | input | 1 | 1 Hz enable for the seconds counter |
| irq_o | output | 1 | level interrupt |
| trig_o | output | 1 | one-cycle timeout trigger |

## Verification
A wrong state or counter value shows up at the 0x40 read in the cycle after the edge that produced it. A missed or extra timeout shows up in raw status bit 0, and on the trigger output, one cycle after the count-enable pulse that moved the counter from 1 to 0. A stale state after a one-shot timeout or a stop shows up as status being set again after later pulses. A split between the halves that is wrong for the configuration appears at once in the merged load and match reads. Errors in the status or mask logic show on the interrupt output in the same cycle as the register value that causes them.

// File: rtl/tht_pkg.sv
package tht_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RTC   = 2'd2
    } run_state_t;

    localparam int unsigned OFS_CFG     = 'h00;
    localparam int unsigned OFS_MODE_A  = 'h04;
    localparam int unsigned OFS_MODE_B  = 'h08;
    localparam int unsigned OFS_CTRL    = 'h0C;
    localparam int unsigned OFS_IMASK   = 'h10;
    localparam int unsigned OFS_RSTAT   = 'h14;
    localparam int unsigned OFS_MSTAT   = 'h18;
    localparam int unsigned OFS_ICLR    = 'h1C;
    localparam int unsigned OFS_LOAD_A  = 'h20;
    localparam int unsigned OFS_LOAD_B  = 'h24;
    localparam int unsigned OFS_MATCH_A = 'h28;
    localparam int unsigned OFS_MATCH_B = 'h2C;
    localparam int unsigned OFS_PRE_A   = 'h30;
    localparam int unsigned OFS_PRE_B   = 'h34;
    localparam int unsigned OFS_PMAT_A  = 'h38;
    localparam int unsigned OFS_PMAT_B  = 'h3C;
    localparam int unsigned OFS_COUNT   = 'h40;

    localparam int          STAT_W      = 7;
    localparam logic [6:0]  MASK_KEEP   = 7'h77;
    localparam int          ST_BIT_TMO  = 0;
    localparam int          ST_BIT_RTC  = 2;

    localparam int          CTRL_W      = 16;
    localparam int          CTL_A_RUN   = 0;
    localparam int          CTL_TRIG_EN = 5;

    localparam int          CFG_W       = 3;
    localparam logic [2:0]  CFG_JOINED  = 3'd0;
    localparam logic [2:0]  CFG_SECONDS = 3'd1;
    localparam logic [2:0]  CFG_SPLIT   = 3'd4;

endpackage

// File: rtl/tht_regs.sv
module tht_regs
    import tht_pkg::*;
#(
    parameter int  HALF_W = 16,
    parameter int  PRE_W  = 8,
    parameter int  ADDR_W = 7,
    localparam int DW     = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [STAT_W-1:0] stat_raw,
    input  logic [DW-1:0]     cnt_val,
    input  logic [DW-1:0]     rtc_val,
    output logic [CFG_W-1:0]  cfg,
    output logic              one_shot,
    output logic              trig_en,
    output logic [DW-1:0]     load_val,
    output logic [DW-1:0]     match_val,
    output logic [STAT_W-1:0] mask,
    output logic              start_req,
    output logic              stop_req,
    output logic [STAT_W-1:0] clr_vec
);

    logic [CFG_W-1:0]  cfg_q;
    logic              mode_a_q;
    logic              mode_b_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_W-1:0] mask_q;
    logic [HALF_W-1:0] load_lo_q, load_hi_q, match_lo_q, match_hi_q;
    logic [PRE_W-1:0]  pre_a_q, pre_b_q, pmat_a_q, pmat_b_q;
    logic              joined;
    logic              a_toggle;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign joined = cfg_q < CFG_SPLIT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            mode_a_q   <= 1'b0;
            mode_b_q   <= 1'b0;
            ctrl_q     <= '0;
            mask_q     <= '0;
            load_lo_q  <= '0;
            load_hi_q  <= '0;
            match_lo_q <= '0;
            match_hi_q <= '0;
            pre_a_q    <= '0;
            pre_b_q    <= '0;
            pmat_a_q   <= '0;
            pmat_b_q   <= '0;
        end else if (wr_en) begin
            if (at(addr, OFS_CFG))    cfg_q    <= wdata[CFG_W-1:0];
            if (at(addr, OFS_MODE_A)) mode_a_q <= wdata[0];
            if (at(addr, OFS_MODE_B)) mode_b_q <= wdata[0];
            if (at(addr, OFS_CTRL))   ctrl_q   <= wdata[CTRL_W-1:0];
            if (at(addr, OFS_IMASK))  mask_q   <= wdata[STAT_W-1:0] & MASK_KEEP;
            if (at(addr, OFS_LOAD_A)) begin
                load_lo_q <= wdata[HALF_W-1:0];
                if (joined) load_hi_q <= wdata[DW-1:HALF_W];
            end
            if (at(addr, OFS_LOAD_B)) load_hi_q <= wdata[HALF_W-1:0];
            if (at(addr, OFS_MATCH_A)) begin
                match_lo_q <= wdata[HALF_W-1:0];
                if (joined) match_hi_q <= wdata[DW-1:HALF_W];
            end
            if (at(addr, OFS_MATCH_B)) match_hi_q <= wdata[HALF_W-1:0];
            if (at(addr, OFS_PRE_A))   pre_a_q    <= wdata[PRE_W-1:0];
            if (at(addr, OFS_PRE_B))   pre_b_q    <= wdata[PRE_W-1:0];
            if (at(addr, OFS_PMAT_A))  pmat_a_q   <= wdata[PRE_W-1:0];
            if (at(addr, OFS_PMAT_B))  pmat_b_q   <= wdata[PRE_W-1:0];
        end
    end

    // Edge of the A run bit, decoded from the write itself.
    assign a_toggle  = wr_en && at(addr, OFS_CTRL) && (wdata[CTL_A_RUN] != ctrl_q[CTL_A_RUN]);
    assign start_req = a_toggle && wdata[CTL_A_RUN];
    assign stop_req  = a_toggle && !wdata[CTL_A_RUN];
    assign clr_vec   = (wr_en && at(addr, OFS_ICLR)) ? wdata[STAT_W-1:0] : '0;

    assign cfg       = cfg_q;
    assign one_shot  = mode_a_q;
    assign trig_en   = ctrl_q[CTL_TRIG_EN];
    assign load_val  = {load_hi_q, load_lo_q};
    assign match_val = {match_hi_q, match_lo_q};
    assign mask      = mask_q;

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFS_CFG):     rdata = DW'(cfg_q);
            ADDR_W'(OFS_MODE_A):  rdata = DW'(mode_a_q);
            ADDR_W'(OFS_MODE_B):  rdata = DW'(mode_b_q);
            ADDR_W'(OFS_CTRL):    rdata = DW'(ctrl_q);
            ADDR_W'(OFS_IMASK):   rdata = DW'(mask_q);
            ADDR_W'(OFS_RSTAT):   rdata = DW'(stat_raw);
            ADDR_W'(OFS_MSTAT):   rdata = DW'(stat_raw & mask_q);
            ADDR_W'(OFS_LOAD_A):  rdata = joined ? {load_hi_q, load_lo_q} : DW'(load_lo_q);
            ADDR_W'(OFS_LOAD_B):  rdata = DW'(load_hi_q);
            ADDR_W'(OFS_MATCH_A): rdata = joined ? {match_hi_q, match_lo_q} : DW'(match_lo_q);
            ADDR_W'(OFS_MATCH_B): rdata = DW'(match_hi_q);
            ADDR_W'(OFS_PRE_A):   rdata = DW'(pre_a_q);
            ADDR_W'(OFS_PRE_B):   rdata = DW'(pre_b_q);
            ADDR_W'(OFS_PMAT_A):  rdata = DW'(pmat_a_q);
            ADDR_W'(OFS_PMAT_B):  rdata = DW'(pmat_b_q);
            ADDR_W'(OFS_COUNT):   rdata = (cfg_q == CFG_SECONDS) ? rtc_val : cnt_val;
            default:              rdata = '0;
        endcase
    end

    AST_MASK_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && at(addr, OFS_IMASK)) |=> ((mask_q & ~MASK_KEEP) == '0)); // R8

endmodule

// File: rtl/tht_core.sv
module tht_core
    import tht_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic [CFG_W-1:0] cfg,
    input  logic             one_shot,
    input  logic             trig_en,
    input  logic [DW-1:0]    load_val,
    input  logic [DW-1:0]    match_val,
    input  logic             cnt_tick,
    input  logic             sec_tick,
    output logic [DW-1:0]    cnt_val,
    output logic [DW-1:0]    rtc_val,
    output logic             tmo_evt,
    output logic             rtc_hit,
    output logic             trig_o
);

    run_state_t cur_q, nxt;
    logic [DW-1:0] cnt_q, rtc_q;
    logic          trig_q;
    logic          ctl_busy;

    assign ctl_busy = start_req || stop_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_IDLE;
        else        cur_q <= nxt;
    end

    // Next state
    always_comb begin
        nxt = cur_q;
        if (stop_req) begin
            nxt = ST_IDLE;                                   // STOP
        end else if (start_req) begin
            if (cfg == CFG_JOINED)       nxt = ST_COUNT;     // START_COUNT
            else if (cfg == CFG_SECONDS) nxt = ST_RTC;       // START_RTC
            else                         nxt = ST_IDLE;      // SPLIT_IGNORE
        end else begin
            unique case (cur_q)
                ST_COUNT: if (tmo_evt && one_shot) nxt = ST_IDLE; // ONESHOT_DONE
                ST_RTC:   nxt = ST_RTC;
                ST_IDLE:  nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // Output events
    always_comb begin
        tmo_evt = 1'b0;
        rtc_hit = 1'b0;
        unique case (cur_q)
            ST_COUNT: tmo_evt = !ctl_busy && cnt_tick && (cnt_q == DW'(1));
            ST_RTC:   rtc_hit = !ctl_busy && sec_tick && ((rtc_q + DW'(1)) == match_val);
            ST_IDLE:  ;
            default:  ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rtc_q  <= '0;
            trig_q <= 1'b0;
        end else begin
            trig_q <= tmo_evt && trig_en;
            if (start_req && cfg == CFG_JOINED) begin
                cnt_q <= load_val;
            end else if (cur_q == ST_COUNT && cnt_tick && !stop_req) begin
                if (cnt_q == DW'(1))  cnt_q <= one_shot ? '0 : load_val; // RELOAD
                else if (cnt_q != '0) cnt_q <= cnt_q - DW'(1);
            end
            if (start_req && cfg == CFG_SECONDS) begin
                rtc_q <= '0;
            end else if (cur_q == ST_RTC && sec_tick && !stop_req) begin
                rtc_q <= rtc_q + DW'(1);
            end
        end
    end

    assign cnt_val = cnt_q;
    assign rtc_val = rtc_q;
    assign trig_o  = trig_q;

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (cur_q == ST_IDLE)); // R10
    AST_NO_SPLIT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && cfg >= CFG_SPLIT) |=> (cur_q == ST_IDLE)); // R10
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_evt && one_shot) |=> (cur_q == ST_IDLE && cnt_q == '0)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_COUNT && !ctl_busy && cnt_tick && cnt_q > DW'(1))
        |=> (cnt_q == $past(cnt_q) - DW'(1))); // R2
    AST_RTC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == ST_RTC && !ctl_busy && sec_tick) |=> (rtc_q == $past(rtc_q) + DW'(1))); // R5

endmodule

// File: rtl/tht_irq.sv
module tht_irq
    import tht_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] stat_raw,
    output logic              irq_o
);

    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    assign stat_raw = stat_q;
    assign irq_o    = |(stat_q & mask);

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[ST_BIT_TMO] && !set_vec[ST_BIT_TMO]) |=> !stat_q[ST_BIT_TMO]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[ST_BIT_TMO] |=> stat_q[ST_BIT_TMO]); // R9

endmodule

// File: rtl/twin_half_timer.sv
module twin_half_timer
    import tht_pkg::*;
#(
    parameter int  HALF_W = 16,
    parameter int  PRE_W  = 8,
    parameter int  ADDR_W = 7,
    localparam int DW     = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              cnt_tick,
    input  logic              sec_tick,
    output logic              irq_o,
    output logic              trig_o
);

    logic [CFG_W-1:0]  cfg;
    logic              one_shot, trig_en, start_req, stop_req;
    logic [DW-1:0]     load_val, match_val, cnt_val, rtc_val;
    logic [STAT_W-1:0] mask, clr_vec, set_vec, stat_raw;
    logic              tmo_evt, rtc_hit;

    tht_regs #(.HALF_W(HALF_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .stat_raw  (stat_raw),
        .cnt_val   (cnt_val),
        .rtc_val   (rtc_val),
        .cfg       (cfg),
        .one_shot  (one_shot),
        .trig_en   (trig_en),
        .load_val  (load_val),
        .match_val (match_val),
        .mask      (mask),
        .start_req (start_req),
        .stop_req  (stop_req),
        .clr_vec   (clr_vec)
    );

    tht_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .cfg       (cfg),
        .one_shot  (one_shot),
        .trig_en   (trig_en),
        .load_val  (load_val),
        .match_val (match_val),
        .cnt_tick  (cnt_tick),
        .sec_tick  (sec_tick),
        .cnt_val   (cnt_val),
        .rtc_val   (rtc_val),
        .tmo_evt   (tmo_evt),
        .rtc_hit   (rtc_hit),
        .trig_o    (trig_o)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[ST_BIT_TMO] = tmo_evt;
        set_vec[ST_BIT_RTC] = rtc_hit;
    end

    tht_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .mask     (mask),
        .stat_raw (stat_raw),
        .irq_o    (irq_o)
    );

    AST_TRIG_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> stat_raw[ST_BIT_TMO]); // R4

endmodule

// File: tb/twin_half_timer_tb_top.sv
module twin_half_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnt_tick = 1'b0;
    logic        sec_tick = 1'b0;
    logic        irq_o, trig_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [6:0] A_CFG = 7'h00, A_MODE_A = 7'h04, A_CTRL = 7'h0C,
                           A_IMASK = 7'h10, A_RSTAT = 7'h14, A_MSTAT = 7'h18,
                           A_ICLR = 7'h1C, A_LOAD_A = 7'h20, A_LOAD_B = 7'h24,
                           A_MATCH_A = 7'h28, A_MATCH_B = 7'h2C, A_PRE_A = 7'h30,
                           A_COUNT = 7'h40;

    always #4 clk = ~clk;

    twin_half_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .sec_tick  (sec_tick),
        .irq_o     (irq_o),
        .trig_o    (trig_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cnt_tick = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_tick = 1'b1; @(posedge clk); @(negedge clk); cnt_tick = 1'b0;
        end
    endtask

    task automatic secs(input int n);
        for (int i = 0; i < n; i++) begin
            sec_tick = 1'b1; @(posedge clk); @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd_chk(A_CFG, 0, "R1 cfg");
        rd_chk(A_CTRL, 0, "R1 ctrl");
        rd_chk(A_LOAD_A, 0, "R1 load");
        rd_chk(A_RSTAT, 0, "R1 status");
        rd_chk(A_COUNT, 0, "R1 count");
        check("R1 irq", {31'd0, irq_o}, 0);
        check("R1 trig", {31'd0, trig_o}, 0);
    endtask

    task automatic t_halves;
        wr(A_LOAD_A, 32'hABCD_1234);
        rd_chk(A_LOAD_A, 32'hABCD_1234, "R7 joined load");
        rd_chk(A_LOAD_B, 32'h0000_ABCD, "R7 high half");
        wr(A_CFG, 4);
        wr(A_LOAD_A, 32'h5566_7788);
        rd_chk(A_LOAD_A, 32'h0000_7788, "R7 split load low only");
        rd_chk(A_LOAD_B, 32'h0000_ABCD, "R6 high kept in split");
        wr(A_MATCH_B, 32'h0000_1111);
        wr(A_MATCH_A, 32'h9999_2222);
        rd_chk(A_MATCH_A, 32'h0000_2222, "R7 split match");
        wr(A_CFG, 0);
        rd_chk(A_LOAD_A, 32'hABCD_7788, "R6 merged after split");
        rd_chk(A_MATCH_A, 32'h1111_2222, "R6 match merged");
        wr(A_PRE_A, 32'h0000_01FF);
        rd_chk(A_PRE_A, 32'h0000_00FF, "R7 prescale");
        wr(A_IMASK, 32'hFF);
        rd_chk(A_IMASK, 32'h77, "R8 mask keep");
        wr(A_LOAD_A, 5);
    endtask

    task automatic t_periodic;
        wr(A_MODE_A, 0);
        wr(A_CTRL, 32'h1);
        rd_chk(A_COUNT, 5, "R2 start load");
        ticks(4);
        rd_chk(A_COUNT, 1, "R2 decrement");
        rd_chk(A_RSTAT, 0, "R2 no early timeout");
        ticks(1);
        rd_chk(A_RSTAT, 1, "R2 timeout status");
        rd_chk(A_COUNT, 5, "R3 periodic reload");
        check("R4 no trig when disabled", {31'd0, trig_o}, 0);
        check("R8 irq on", {31'd0, irq_o}, 1);
        rd_chk(A_MSTAT, 1, "R8 masked status");
        wr(A_IMASK, 0);
        check("R8 irq masked", {31'd0, irq_o}, 0);
        rd_chk(A_MSTAT, 0, "R8 masked status zero");
        rd_chk(A_RSTAT, 1, "R8 raw stays");
        wr(A_ICLR, 1);
        rd_chk(A_RSTAT, 0, "R9 clear");
        ticks(2);
        rd_chk(A_COUNT, 3, "R2 count 3");
        wr(A_CTRL, 32'h21);
        rd_chk(A_COUNT, 3, "R10 no restart");
        ticks(2);
        check("R4 no trig before timeout", {31'd0, trig_o}, 0);
        ticks(1);
        check("R4 trig pulse", {31'd0, trig_o}, 1);
        @(negedge clk);
        check("R4 trig one cycle", {31'd0, trig_o}, 0);
        wr(A_CTRL, 32'h20);
        ticks(2);
        rd_chk(A_COUNT, 5, "R10 stopped");
    endtask

    task automatic t_oneshot;
        wr(A_ICLR, 32'h7F);
        wr(A_MODE_A, 1);
        wr(A_LOAD_A, 3);
        wr(A_CTRL, 32'h21);
        ticks(3);
        rd_chk(A_RSTAT, 1, "R3 one-shot timeout");
        rd_chk(A_COUNT, 0, "R3 one-shot holds zero");
        wr(A_ICLR, 1);
        ticks(3);
        rd_chk(A_RSTAT, 0, "R3 one-shot no retrigger");
        rd_chk(A_COUNT, 0, "R3 stays zero");
    endtask

    task automatic t_set_wins;
        wr(A_MODE_A, 0);
        wr(A_LOAD_A, 2);
        wr(A_CTRL, 32'h20);
        wr(A_CTRL, 32'h21);
        rd_chk(A_COUNT, 2, "R2 load 2");
        ticks(1);
        wr_tick(A_ICLR, 1);
        rd_chk(A_RSTAT, 1, "R9 set beats clear");
        wr(A_ICLR, 1);
        rd_chk(A_RSTAT, 0, "R9 later clear");
        wr(A_CTRL, 32'h20);
    endtask

    task automatic t_rtc;
        wr(A_CFG, 1);
        wr(A_MATCH_A, 3);
        wr(A_IMASK, 4);
        wr(A_CTRL, 32'h21);
        rd_chk(A_COUNT, 0, "R5 seconds start");
        secs(2);
        rd_chk(A_COUNT, 2, "R5 seconds count");
        rd_chk(A_RSTAT, 0, "R5 no early match");
        check("R5 irq low", {31'd0, irq_o}, 0);
        secs(1);
        rd_chk(A_COUNT, 3, "R5 count at match");
        rd_chk(A_RSTAT, 4, "R5 match status");
        check("R5 irq high", {31'd0, irq_o}, 1);
        secs(1);
        rd_chk(A_RSTAT, 4, "R5 match sticky");
    endtask

    task automatic t_split_nostart;
        wr(A_CTRL, 32'h20);
        wr(A_ICLR, 32'h7F);
        wr(A_IMASK, 1);
        wr(A_CFG, 4);
        wr(A_CTRL, 32'h21);
        ticks(6);
        rd_chk(A_RSTAT, 0, "R10 split no start");
        check("R10 split irq", {31'd0, irq_o}, 0);
        check("R10 split trig", {31'd0, trig_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halves();
        t_periodic();
        t_oneshot();
        t_set_wins();
        t_rtc();
        t_split_nostart();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule